// File: doc/BRIEF.md
# Serial Command Decoder for a Board Logic Device

This block is the target side of a mode-0 SPI link: a host selects it, sends one command byte, and then sends or receives payload bytes whose meaning depends on that command. The commands load an 8-bit configuration register that holds LED and NAND chip-enable controls, switch a separate LED on or off, write bytes to a NAND byte port, read bytes back from that port, and read a window of memory starting at a 24-bit address.

All serial inputs are brought into the system clock domain through a synchronizer chain, and edges of the serial clock are detected there. The serial clock must therefore be well below the system clock: each serial clock phase must last at least eight system clocks. NAND write payload arrives two bits per serial clock. The NAND device and the memory are outside the block. Each one is reached through a strobe, and its read data must be valid combinationally in the cycle the strobe is high.

Top module: `cpld_spi_decoder`

## Requirements
- R1: After reset `cfg_q` is 8'h1F, `led5_on`, `spi_miso` and all three strobes are 0. In `cfg_q`, bits 3:0 are the active-low LED1..LED4 controls (1 = off), bit 4 is the active-low NAND chip enable (1 = deasserted), and bits 7:5 are 0.
- R2: While `spi_cs_n` is low, the first byte is the command. It is taken one bit per rising `spi_sclk` edge from `spi_mosi`, most significant bit first.
- R3: After command 8'h09, every complete byte that follows loads `cfg_q`.
- R4: Command 8'h0C sets `led5_on` and command 8'h0D clears it. Later bytes in the same selection have no effect.
- R5: After command 8'h08, payload bytes arrive two bits per rising edge: `spi_mosi` carries the higher bit and `spi_lane2` the lower bit, highest pair first, four edges per byte. Each byte appears on `nand_wr_data` with a one-cycle `nand_wr_stb` once the following byte completes, so the final byte before deselection (the idle byte) is never emitted.
- R6: After command 8'h0A and one idle byte, each returned byte is fetched with a one-cycle `nand_rd_stb`. `nand_rd_data` is taken in the strobe cycle. The byte is shifted out on `spi_miso` MSB first, and the output changes only after a falling `spi_sclk` edge. A fetch is issued when the idle byte completes and when each data byte completes, so n returned bytes cost n+1 strobes.
- R7: After command 8'h0B, three address bytes (most significant first) and one idle byte, data bytes come from consecutive addresses. Each fetch pulses `mem_rd_stb` with `mem_addr`, takes `mem_rd_data` in that cycle, and then increments the address, carrying across byte boundaries. As in R6, n bytes cost n+1 fetches.
- R8: Raising `spi_cs_n` discards any partial byte and any NAND write byte that is still held. The first byte after the next selection is decoded as a command.
- R9: A command byte with any other value causes every following byte in that selection to be ignored: `cfg_q`, `led5_on` and all strobes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in (higher bit of a pair in two-bit format) |
| spi_lane2 | input | 1 | Second select line used as the lower data bit in two-bit format |
| spi_miso | output | 1 | Serial data out |
| cfg_q | output | 8 | Configuration register |
| led5_on | output | 1 | LED5 drive, 1 = on |
| nand_wr_stb | output | 1 | One-cycle NAND write strobe |
| nand_wr_data | output | 8 | NAND write byte |
| nand_rd_stb | output | 1 | One-cycle NAND read strobe |
| nand_rd_data | input | 8 | NAND read byte, valid in strobe cycle |
| mem_rd_stb | output | 1 | One-cycle memory read strobe |
| mem_addr | output | 24 | Memory read address |
| mem_rd_data | input | 8 | Memory read byte, valid in strobe cycle |

## Verification
The bench ends a NAND write with the selection dropped right after a data byte, then starts a new write. A decoder that kept the held byte would emit that stale byte, and a decoder that treated the last byte as data would emit the idle byte; both show up as unexpected items in the write scoreboard. A half-received byte followed by deselection checks that stale bits are not carried into the next command; a decoder that kept them would misread 8'h09 and leave the configuration unchanged. The fast read starts at an address ending in 8'hFE, so a missing carry shows up as a wrong fetch address. Unknown opcodes are followed by bytes that look like valid commands, and the bench confirms that the register, the LED output and the strobes stay unchanged.

// File: rtl/cpld_spi_pkg.sv
// Shared types for the serial command decoder: decoder states and opcodes.
package cpld_spi_pkg;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_CFG,
        ST_NWR,
        ST_NRD_IDLE,
        ST_NRD_DATA,
        ST_FR_ADDR,
        ST_FR_IDLE,
        ST_FR_DATA,
        ST_DROP
    } dec_state_t;

    localparam logic [7:0] OP_NAND_WR  = 8'h08;
    localparam logic [7:0] OP_CFG_WR   = 8'h09;
    localparam logic [7:0] OP_NAND_RD  = 8'h0A;
    localparam logic [7:0] OP_FAST_RD  = 8'h0B;
    localparam logic [7:0] OP_LED_ON   = 8'h0C;
    localparam logic [7:0] OP_LED_OFF  = 8'h0D;

endpackage

// File: rtl/cpld_spi_frontend.sv
// Synchronizes the serial pins into the clk domain and detects serial clock
// edges. Edges are reported only while the select is low.
// Assumes each serial clock phase lasts longer than STAGES+2 system clocks.
module cpld_spi_frontend #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    input  logic lane2,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_idle,
    output logic dat_hi,
    output logic dat_lo
);
    localparam int W  = 4;
    localparam int PW = STAGES * W;

    logic [PW-1:0] pipe;
    logic [W-1:0]  cur;
    logic          sclk_prev;

    generate
        if (STAGES == 1) begin : g_one
            // single synchronizer stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= 4'b0100;
                else        pipe <= {sclk, cs_n, mosi, lane2};
            end
        end else begin : g_many
            // multi-stage synchronizer chain, oldest sample at the top
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= {STAGES{4'b0100}};
                else        pipe <= {pipe[PW-W-1:0], sclk, cs_n, mosi, lane2};
            end
        end
    endgenerate

    assign cur = pipe[PW-1 -: W];

    // remember last synchronized serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= cur[3];
    end

    assign sclk_rise = cur[3] & ~sclk_prev & ~cur[2];
    assign sclk_fall = ~cur[3] & sclk_prev & ~cur[2];
    assign sel_idle  = cur[2];
    assign dat_hi    = cur[1];
    assign dat_lo    = cur[0];

endmodule

// File: rtl/cpld_spi_rx.sv
// Assembles incoming bits into bytes, one or two bits per rising edge.
// Emits a one-cycle done pulse with the completed byte.
// Assumes 'dual' is stable between edges; 'clear' discards a partial byte.
module cpld_spi_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rise,
    input  logic              dual,
    input  logic              d_hi,
    input  logic              d_lo,
    output logic              done,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;

    logic [BYTE_W-1:0] sr, nxt_sr;
    logic [CNT_W-1:0]  cnt, nxt_cnt;

    // next shift value and bit count for this edge
    always_comb begin
        nxt_sr  = dual ? {sr[BYTE_W-3:0], d_hi, d_lo} : {sr[BYTE_W-2:0], d_hi};
        nxt_cnt = cnt + (dual ? CNT_W'(2) : CNT_W'(1));
    end

    // shift register, bit counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr   <= '0;
            cnt  <= '0;
            done <= 1'b0;
            if (!rst_n) byte_q <= '0;
        end else begin
            done <= 1'b0;
            if (rise) begin
                if (nxt_cnt == CNT_W'(BYTE_W)) begin
                    byte_q <= nxt_sr;
                    done   <= 1'b1;
                    sr     <= '0;
                    cnt    <= '0;
                end else begin
                    sr  <= nxt_sr;
                    cnt <= nxt_cnt;
                end
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/cpld_spi_tx.sv
// Holds the byte to return and shifts it out MSB first, one bit per falling
// serial clock edge. Assumes 'load' never coincides with 'fall'.
module cpld_spi_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              fall,
    output logic              miso
);
    logic [BYTE_W-1:0] sr;

    // load fetched byte, shift on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr   <= '0;
            miso <= 1'b0;
        end else if (load) begin
            sr <= load_val;
        end else if (fall) begin
            miso <= sr[BYTE_W-1];
            sr   <= {sr[BYTE_W-2:0], 1'b0};
        end
    end

    // R6
    miso_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(fall) || $past(clear)));

endmodule

// File: rtl/cpld_spi_decoder.sv
// Serial command decoder: decodes the first byte of each selection and
// routes the following bytes to the configuration register, the LED5 output,
// the NAND byte port or the memory read port.
// Assumes external read data is valid in the cycle its strobe is high.
module cpld_spi_decoder
    import cpld_spi_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         ADDR_W      = 24,
    parameter logic [7:0] CFG_INIT    = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              spi_lane2,
    output logic              spi_miso,
    output logic [7:0]        cfg_q,
    output logic              led5_on,
    output logic              nand_wr_stb,
    output logic [7:0]        nand_wr_data,
    output logic              nand_rd_stb,
    input  logic [7:0]        nand_rd_data,
    output logic              mem_rd_stb,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int ABC_W      = $clog2(ADDR_BYTES + 1);

    logic             rise, fall, sel_idle, dat_hi, dat_lo;
    logic             rx_done;
    logic [7:0]       rx_byte;
    logic             dual;
    dec_state_t       st;
    logic             pend;
    logic [7:0]       pend_byte;
    logic [ABC_W-1:0] abyte;

    cpld_spi_frontend #(.STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .lane2(spi_lane2), .sclk_rise(rise),
        .sclk_fall(fall), .sel_idle(sel_idle), .dat_hi(dat_hi), .dat_lo(dat_lo)
    );

    assign dual = (st == ST_NWR);

    cpld_spi_rx #(.BYTE_W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(sel_idle), .rise(rise), .dual(dual),
        .d_hi(dat_hi), .d_lo(dat_lo), .done(rx_done), .byte_q(rx_byte)
    );

    cpld_spi_tx #(.BYTE_W(8)) u_tx (
        .clk(clk), .rst_n(rst_n), .clear(sel_idle),
        .load(nand_rd_stb | mem_rd_stb),
        .load_val(mem_rd_stb ? mem_rd_data : nand_rd_data),
        .fall(fall), .miso(spi_miso)
    );

    // command decode and per-command byte handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_CMD;
            cfg_q        <= CFG_INIT;
            led5_on      <= 1'b0;
            nand_wr_stb  <= 1'b0;
            nand_wr_data <= '0;
            nand_rd_stb  <= 1'b0;
            mem_rd_stb   <= 1'b0;
            mem_addr     <= '0;
            pend         <= 1'b0;
            pend_byte    <= '0;
            abyte        <= '0;
        end else begin
            nand_wr_stb <= 1'b0;
            nand_rd_stb <= 1'b0;
            mem_rd_stb  <= 1'b0;
            if (mem_rd_stb) mem_addr <= mem_addr + ADDR_W'(1);
            if (sel_idle) begin
                st    <= ST_CMD;
                pend  <= 1'b0;
                abyte <= '0;
            end else if (rx_done) begin
                case (st)
                    ST_CMD: begin
                        case (rx_byte)
                            OP_NAND_WR: st <= ST_NWR;
                            OP_CFG_WR:  st <= ST_CFG;
                            OP_NAND_RD: st <= ST_NRD_IDLE;
                            OP_FAST_RD: begin
                                st    <= ST_FR_ADDR;
                                abyte <= '0;
                            end
                            OP_LED_ON: begin
                                led5_on <= 1'b1;
                                st      <= ST_DROP;
                            end
                            OP_LED_OFF: begin
                                led5_on <= 1'b0;
                                st      <= ST_DROP;
                            end
                            default: st <= ST_DROP;
                        endcase
                    end
                    ST_CFG: cfg_q <= rx_byte;
                    ST_NWR: begin
                        if (pend) begin
                            nand_wr_stb  <= 1'b1;
                            nand_wr_data <= pend_byte;
                        end
                        pend_byte <= rx_byte;
                        pend      <= 1'b1;
                    end
                    ST_NRD_IDLE, ST_NRD_DATA: begin
                        nand_rd_stb <= 1'b1;
                        st          <= ST_NRD_DATA;
                    end
                    ST_FR_ADDR: begin
                        mem_addr <= {mem_addr[ADDR_W-9:0], rx_byte};
                        abyte    <= abyte + ABC_W'(1);
                        if (abyte == ABC_W'(ADDR_BYTES - 1)) st <= ST_FR_IDLE;
                    end
                    ST_FR_IDLE, ST_FR_DATA: begin
                        mem_rd_stb <= 1'b1;
                        st         <= ST_FR_DATA;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idle |=> (st == ST_CMD));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_stb |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_wr_stb |=> !nand_wr_stb);

    // R4
    led_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led5_on) |-> ($past(rx_done) && $past(st) == ST_CMD));

    // R3
    cfg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> ($past(rx_done) && $past(st) == ST_CFG));

    // R9
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DROP) |=> !(nand_wr_stb || nand_rd_stb || mem_rd_stb));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_rd_stb && mem_rd_stb));

endmodule

// File: tb/test_cpld_spi_decoder.sv
// Scoreboard bench: driver tasks queue expected NAND writes and memory
// fetch addresses; a monitor pops and compares them as strobes appear.
module test_cpld_spi_decoder;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, lane2 = 1'b0;
    logic        miso;
    logic [7:0]  cfg_q;
    logic        led5_on;
    logic        nand_wr_stb, nand_rd_stb, mem_rd_stb;
    logic [7:0]  nand_wr_data, nand_rd_data, mem_rd_data;
    logic [23:0] mem_addr;
    logic [7:0]  nand_idx;

    int tests = 0, fails = 0, nrd_cnt = 0;
    bit finished = 0;
    logic [7:0]  wr_q[$];
    logic [23:0] ad_q[$];

    always #4 clk = ~clk;

    cpld_spi_decoder i_cpld_spi_decoder (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_lane2(lane2), .spi_miso(miso), .cfg_q(cfg_q),
        .led5_on(led5_on), .nand_wr_stb(nand_wr_stb), .nand_wr_data(nand_wr_data),
        .nand_rd_stb(nand_rd_stb), .nand_rd_data(nand_rd_data),
        .mem_rd_stb(mem_rd_stb), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hC3;
    endfunction

    function automatic logic [7:0] nandf(input logic [7:0] k);
        return k * 8'd37 + 8'h11;
    endfunction

    assign mem_rd_data  = memf(mem_addr);
    assign nand_rd_data = nandf(nand_idx);

    always @(posedge clk) begin
        if (!rst_n) nand_idx <= 8'd0;
        else if (nand_rd_stb) nand_idx <= nand_idx + 8'd1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares strobes against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (nand_wr_stb) begin
                if (wr_q.size() == 0) chk("R5 unexpected NAND write", {24'd0, nand_wr_data}, 32'hFFFF_FFFF);
                else chk("R5 NAND write byte", {24'd0, nand_wr_data}, {24'd0, wr_q.pop_front()});
            end
            if (mem_rd_stb) begin
                if (ad_q.size() == 0) chk("R7 unexpected fetch", {8'd0, mem_addr}, 32'hFFFF_FFFF);
                else chk("R7 fetch address", {8'd0, mem_addr}, {8'd0, ad_q.pop_front()});
            end
            if (nand_rd_stb) nrd_cnt++;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clks(HP);
    endtask

    task automatic desel();
        wait_clks(HP);
        cs_n = 1'b1;
        wait_clks(4 * HP);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clks(HP);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clks(HP);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic xfer2(input logic [7:0] tx);
        for (int i = 3; i >= 0; i--) begin
            mosi  = tx[2*i+1];
            lane2 = tx[2*i];
            wait_clks(HP);
            sclk = 1'b1;
            wait_clks(HP);
            sclk = 1'b0;
        end
        lane2 = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int base;
        wait_clks(10);
        rst_n = 1'b1;
        wait_clks(4);

        // R1 reset state
        chk("R1 cfg reset", {24'd0, cfg_q}, 32'h1F);
        chk("R1 led5 reset", {31'd0, led5_on}, 32'd0);
        chk("R1 miso reset", {31'd0, miso}, 32'd0);
        chk("R1 strobes reset", {29'd0, nand_wr_stb, nand_rd_stb, mem_rd_stb}, 32'd0);

        // R2, R3 config writes, command MSB first
        sel(); xfer(8'h09, rx); xfer(8'hA6, rx);
        chk("R3 cfg first byte", {24'd0, cfg_q}, 32'hA6);
        xfer(8'h3C, rx);
        chk("R3 cfg second byte", {24'd0, cfg_q}, 32'h3C);
        desel();
        chk("R2 cfg kept after deselect", {24'd0, cfg_q}, 32'h3C);

        // R4 LED commands, trailing bytes ignored
        sel(); xfer(8'h0C, rx);
        chk("R4 led on", {31'd0, led5_on}, 32'd1);
        xfer(8'h0D, rx);
        chk("R4 trailing byte ignored", {31'd0, led5_on}, 32'd1);
        desel();
        sel(); xfer(8'h0D, rx); desel();
        chk("R4 led off", {31'd0, led5_on}, 32'd0);

        // R5 dual-lane NAND write, idle byte not emitted
        wr_q.push_back(8'hA5); wr_q.push_back(8'h3C); wr_q.push_back(8'h0F);
        sel(); xfer(8'h08, rx);
        xfer2(8'hA5); xfer2(8'h3C); xfer2(8'h0F); xfer2(8'h00);
        desel();
        chk("R5 all writes seen", wr_q.size(), 32'd0);

        // R8 held write byte dropped on deselect
        wr_q.push_back(8'h11);
        sel(); xfer(8'h08, rx); xfer2(8'h11); xfer2(8'h22); desel();
        wr_q.push_back(8'h77);
        sel(); xfer(8'h08, rx); xfer2(8'h77); xfer2(8'h00); desel();
        chk("R8 held byte discarded", wr_q.size(), 32'd0);

        // R8 partial byte discarded
        sel(); xbits(8'hFF, 4, rx); desel();
        sel(); xfer(8'h09, rx); xfer(8'h5A, rx); desel();
        chk("R8 partial byte discarded", {24'd0, cfg_q}, 32'h5A);

        // R9 unknown opcode ignores the rest
        sel(); xfer(8'h3E, rx); xfer(8'h09, rx); xfer(8'h77, rx); xfer(8'h0C, rx); desel();
        chk("R9 cfg unchanged", {24'd0, cfg_q}, 32'h5A);
        chk("R9 led unchanged", {31'd0, led5_on}, 32'd0);

        // R6 NAND read after idle byte, prefetch count
        base = nrd_cnt;
        sel(); xfer(8'h0A, rx); xfer(8'h00, rx);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, rx);
            chk("R6 NAND read byte", {24'd0, rx}, {24'd0, nandf(8'(base + k))});
        end
        desel();
        chk("R6 read strobe count", nrd_cnt - base, 32'd4);

        // R7 fast read across an address carry
        ad_q.push_back(24'h0123FE); ad_q.push_back(24'h0123FF);
        ad_q.push_back(24'h012400); ad_q.push_back(24'h012401);
        sel(); xfer(8'h0B, rx); xfer(8'h01, rx); xfer(8'h23, rx); xfer(8'hFE, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx); chk("R7 byte at 0123FE", {24'd0, rx}, {24'd0, memf(24'h0123FE)});
        xfer(8'h00, rx); chk("R7 byte at 0123FF", {24'd0, rx}, {24'd0, memf(24'h0123FF)});
        xfer(8'h00, rx); chk("R7 byte at 012400", {24'd0, rx}, {24'd0, memf(24'h012400)});
        desel();
        chk("R7 all fetches seen", ad_q.size(), 32'd0);

        finished = 1;
        summary();
        $finish;
    end

endmodule